// File: doc/BRIEF.md
# Priority Address Window Decoder

The decoder steers a memory request to one of several targets. Software, or a boot sequencer, loads a table of inclusive address windows through a configuration port. Each write appends one window and names the target that window belongs to. A request carries a byte address, an access size in bytes and a read/write strobe.

A window matches only when every byte of the access lies inside it. When several windows match, the one loaded last wins, so a later mapping can carve a hole out of an earlier, wider one. The response comes one cycle after the request. It gives the matching window's index, its target id and the offset of the access from that window's base. If no window matches, the response flags a bad-address error and selects no target.

Configuration writes are checked before they are stored. A write whose end lies below its start is rejected. A write to a full table is also rejected. Either rejection is flagged one cycle after the write, and the table is left unchanged.

Top module: `addr_range_dec`

## Requirements
- R1: A window hits only if start <= addr and addr + size - 1 <= end, both bounds inclusive, so an access whose last byte passes the end misses that window.
- R2: When several windows hit, the one appended most recently (highest index) is selected.
- R3: On a hit, rsp_tgt_o carries the selected window's target id, rsp_idx_o its index (0 = first appended), and rsp_offset_o equals addr minus that window's start.
- R4: When no window hits, rsp_err_o is 1, rsp_hit_o is 0, and rsp_tgt_o, rsp_idx_o and rsp_offset_o are all 0. rsp_hit_o and rsp_err_o are never both 1.
- R5: An access with size 0 misses. An access whose last byte addr + size - 1 wraps past the top of the address space also misses.
- R6: A configuration write with end < start is not stored, and cfg_rej_o is 1 in the cycle after the write.
- R7: A configuration write to a table that already holds N_WIN windows is not stored, and cfg_rej_o is 1 in the cycle after the write. A write that is accepted leaves cfg_rej_o at 0 in the cycle after it.
- R8: rsp_valid_o is 1 exactly in the cycle after each cycle with req_valid_i = 1. rsp_we_o then equals that request's req_we_i. With no request, rsp_valid_o, rsp_hit_o, rsp_err_o and rsp_we_o are 0.
- R9: After reset the table is empty, every request misses, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Append one window |
| cfg_start_i | input | AW | First byte of the window |
| cfg_end_i | input | AW | Last byte of the window (inclusive) |
| cfg_tgt_i | input | TW | Target id of the window |
| cfg_rej_o | output | 1 | Previous configuration write was rejected |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | Write strobe of the request |
| req_addr_i | input | AW | Byte address of the request |
| req_size_i | input | SW | Access size in bytes |
| rsp_valid_o | output | 1 | Response present |
| rsp_we_o | output | 1 | Forwarded write strobe |
| rsp_hit_o | output | 1 | A window matched |
| rsp_err_o | output | 1 | Bad address: no window matched |
| rsp_idx_o | output | IW | Index of the selected window |
| rsp_tgt_o | output | TW | Target id of the selected window |
| rsp_offset_o | output | AW | Address relative to the window start |

## Verification
A corrupted table entry, or a wrong append pointer, shows up on the first request that reaches the affected window. That request returns a wrong target, index or offset, or an unexpected error, exactly one cycle after it was issued.

A pointer that runs past the table end shows up differently. A ninth write is then not flagged, and the next request into that ninth window's range hits where it should miss.

A reversed priority encoder is visible only when windows overlap. Overlapping windows and accesses that straddle a window end are therefore generated on purpose.

// File: rtl/adr_dec_pkg.sv
package adr_dec_pkg;
  typedef enum logic [1:0] {
    RSP_IDLE = 2'd0,
    RSP_HIT  = 2'd1,
    RSP_MISS = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/adr_win_table.sv
module adr_win_table #(
  parameter int N_WIN = 8,
  parameter int AW    = 32,
  parameter int TW    = 4,
  localparam int CW   = $clog2(N_WIN + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            start_i,
  input  logic [AW-1:0]            end_i,
  input  logic [TW-1:0]            tgt_i,
  output logic [N_WIN-1:0][AW-1:0] start_o,
  output logic [N_WIN-1:0][AW-1:0] end_o,
  output logic [N_WIN-1:0][TW-1:0] tgt_o,
  output logic [N_WIN-1:0]         vld_o,
  output logic [CW-1:0]            count_o,
  output logic                     rej_o
);
  logic [CW-1:0] count_q;
  logic          full, legal, accept;

  assign full   = (count_q == CW'(N_WIN));
  assign legal  = (end_i >= start_i);
  assign accept = we_i && legal && !full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      rej_o   <= 1'b0;
    end else begin
      rej_o <= we_i && !accept;
      if (accept) count_q <= count_q + CW'(1);
    end
  end

  for (genvar i = 0; i < N_WIN; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        start_o[i] <= '0;
        end_o[i]   <= '0;
        tgt_o[i]   <= '0;
      end else if (accept && count_q == CW'(i)) begin
        start_o[i] <= start_i;
        end_o[i]   <= end_i;
        tgt_o[i]   <= tgt_i;
      end
    end
    assign vld_o[i] = (count_q > CW'(i));
  end

  assign count_o = count_q;
endmodule

// File: rtl/adr_win_match.sv
module adr_win_match #(
  parameter int N_WIN = 8,
  parameter int AW    = 32,
  parameter int SW    = 4
) (
  input  logic [N_WIN-1:0][AW-1:0] start_i,
  input  logic [N_WIN-1:0][AW-1:0] end_i,
  input  logic [N_WIN-1:0]         vld_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [SW-1:0]            size_i,
  output logic [N_WIN-1:0]         hit_o
);
  logic [AW:0]   last_ext;
  logic [AW-1:0] last;
  logic          ok;

  // Last byte of the access, one extra bit to catch a wrap.
  assign last_ext = {1'b0, addr_i} + (AW+1)'(size_i) - (AW+1)'(1);
  assign last     = last_ext[AW-1:0];
  assign ok       = (size_i != '0) && !last_ext[AW];

  for (genvar i = 0; i < N_WIN; i++) begin : g_cmp
    assign hit_o[i] = ok && vld_i[i] && (addr_i >= start_i[i]) && (last <= end_i[i]);
  end
endmodule

// File: rtl/adr_prio_pick.sv
module adr_prio_pick #(
  parameter int N_WIN = 8,
  localparam int IW   = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
  input  logic [N_WIN-1:0] hit_i,
  output logic             any_o,
  output logic [IW-1:0]    sel_o
);
  // Highest index wins: newest window overrides older ones.
  always_comb begin
    sel_o = '0;
    for (int i = 0; i < N_WIN; i++) begin
      if (hit_i[i]) sel_o = IW'(i);
    end
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/addr_range_dec.sv
module addr_range_dec
  import adr_dec_pkg::*;
#(
  parameter int N_WIN = 8,
  parameter int AW    = 32,
  parameter int SW    = 4,
  parameter int TW    = 4,
  localparam int IW   = (N_WIN > 1) ? $clog2(N_WIN) : 1,
  localparam int CW   = $clog2(N_WIN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_start_i,
  input  logic [AW-1:0] cfg_end_i,
  input  logic [TW-1:0] cfg_tgt_i,
  output logic          cfg_rej_o,
  input  logic          req_valid_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [SW-1:0] req_size_i,
  output logic          rsp_valid_o,
  output logic          rsp_we_o,
  output logic          rsp_hit_o,
  output logic          rsp_err_o,
  output logic [IW-1:0] rsp_idx_o,
  output logic [TW-1:0] rsp_tgt_o,
  output logic [AW-1:0] rsp_offset_o
);
  logic [N_WIN-1:0][AW-1:0] win_start, win_end;
  logic [N_WIN-1:0][TW-1:0] win_tgt;
  logic [N_WIN-1:0]         win_vld, win_hit;
  logic [CW-1:0]            cfg_count;
  logic                     any_hit;
  logic [IW-1:0]            sel;
  rsp_kind_e                kind_d, kind_q;

  adr_win_table #(.N_WIN(N_WIN), .AW(AW), .TW(TW)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(cfg_we_i), .start_i(cfg_start_i), .end_i(cfg_end_i), .tgt_i(cfg_tgt_i),
    .start_o(win_start), .end_o(win_end), .tgt_o(win_tgt), .vld_o(win_vld),
    .count_o(cfg_count), .rej_o(cfg_rej_o)
  );

  adr_win_match #(.N_WIN(N_WIN), .AW(AW), .SW(SW)) u_match (
    .start_i(win_start), .end_i(win_end), .vld_i(win_vld),
    .addr_i(req_addr_i), .size_i(req_size_i), .hit_o(win_hit)
  );

  adr_prio_pick #(.N_WIN(N_WIN)) u_pick (
    .hit_i(win_hit), .any_o(any_hit), .sel_o(sel)
  );

  always_comb begin
    if (!req_valid_i) kind_d = RSP_IDLE;
    else if (any_hit) kind_d = RSP_HIT;
    else              kind_d = RSP_MISS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q       <= RSP_IDLE;
      rsp_we_o     <= 1'b0;
      rsp_idx_o    <= '0;
      rsp_tgt_o    <= '0;
      rsp_offset_o <= '0;
    end else begin
      kind_q   <= kind_d;
      rsp_we_o <= req_valid_i && req_we_i;
      if (kind_d == RSP_HIT) begin
        rsp_idx_o    <= sel;
        rsp_tgt_o    <= win_tgt[sel];
        rsp_offset_o <= req_addr_i - win_start[sel];
      end else begin
        rsp_idx_o    <= '0;
        rsp_tgt_o    <= '0;
        rsp_offset_o <= '0;
      end
    end
  end

  assign rsp_valid_o = (kind_q != RSP_IDLE);
  assign rsp_hit_o   = (kind_q == RSP_HIT);
  assign rsp_err_o   = (kind_q == RSP_MISS);
endmodule

// File: rtl/addr_range_dec_chk.sv
module addr_range_dec_chk #(
  parameter int N_WIN = 8,
  parameter int AW    = 32,
  parameter int SW    = 4,
  parameter int TW    = 4,
  parameter int CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [AW-1:0] cfg_start_i,
  input logic [AW-1:0] cfg_end_i,
  input logic          cfg_rej_o,
  input logic [CW-1:0] cfg_count,
  input logic          req_valid_i,
  input logic          req_we_i,
  input logic [SW-1:0] req_size_i,
  input logic          rsp_valid_o,
  input logic          rsp_we_o,
  input logic          rsp_hit_o,
  input logic          rsp_err_o,
  input logic [TW-1:0] rsp_tgt_o,
  input logic [AW-1:0] rsp_offset_o
);
  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_hit_o && !rsp_err_o && !rsp_we_o));
  a_r8_we_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_we_o == $past(req_we_i)));
  a_r4_hit_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_hit_o != rsp_err_o));
  a_r4_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_tgt_o == '0 && rsp_offset_o == '0));
  a_r5_size_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == '0) |=> rsp_err_o);
  a_r6_illegal_rej: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_end_i < cfg_start_i) |=> cfg_rej_o);
  a_r7_full_rej: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_count == CW'(N_WIN)) |=> (cfg_rej_o && $stable(cfg_count)));
  a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_count <= CW'(N_WIN));
endmodule

bind addr_range_dec addr_range_dec_chk #(
  .N_WIN(N_WIN), .AW(AW), .SW(SW), .TW(TW), .CW(CW)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_start_i(cfg_start_i),
  .cfg_end_i(cfg_end_i), .cfg_rej_o(cfg_rej_o), .cfg_count(cfg_count),
  .req_valid_i(req_valid_i), .req_we_i(req_we_i), .req_size_i(req_size_i),
  .rsp_valid_o(rsp_valid_o), .rsp_we_o(rsp_we_o), .rsp_hit_o(rsp_hit_o),
  .rsp_err_o(rsp_err_o), .rsp_tgt_o(rsp_tgt_o), .rsp_offset_o(rsp_offset_o)
);

// File: tb/addr_range_dec_tb_top.sv
`timescale 1ns/1ps
module addr_range_dec_tb_top;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int SW = 4;
  localparam int TW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [AW-1:0] cfg_start_i = '0, cfg_end_i = '0;
  logic [TW-1:0] cfg_tgt_i = '0;
  logic          cfg_rej_o;
  logic          req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [SW-1:0] req_size_i = '0;
  logic          rsp_valid_o, rsp_we_o, rsp_hit_o, rsp_err_o;
  logic [2:0]    rsp_idx_o;
  logic [TW-1:0] rsp_tgt_o;
  logic [AW-1:0] rsp_offset_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk_i = ~clk_i;

  addr_range_dec #(.N_WIN(N), .AW(AW), .SW(SW), .TW(TW)) dut_i (.*);

  // Bench model of the window table
  logic [AW-1:0] ms [N];
  logic [AW-1:0] me [N];
  logic [TW-1:0] mt [N];
  int mcnt;

  // Expected response: {valid, we, hit, err, idx[3], tgt[4], offset[32]}
  function automatic logic [42:0] exp_rsp(logic [AW-1:0] a, logic [SW-1:0] sz, logic we);
    logic [63:0] last;
    int sel;
    sel  = -1;
    last = {32'd0, a} + 64'(sz) - 64'd1;
    if (sz != 0 && last <= 64'hFFFF_FFFF)
      for (int i = 0; i < mcnt; i++)
        if (a >= ms[i] && last[31:0] <= me[i]) sel = i;
    if (sel < 0) return {1'b1, we, 1'b0, 1'b1, 3'd0, 4'd0, 32'd0};
    return {1'b1, we, 1'b1, 1'b0, 3'(sel), mt[sel], a - ms[sel]};
  endfunction

  task automatic check(string req, logic [42:0] act, logic [42:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    mcnt = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic cfg(string req, logic [AW-1:0] s, logic [AW-1:0] e, logic [TW-1:0] t);
    logic exp_rej;
    exp_rej = (e < s) || (mcnt == N);
    cfg_we_i = 1'b1; cfg_start_i = s; cfg_end_i = e; cfg_tgt_i = t;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (!exp_rej) begin ms[mcnt] = s; me[mcnt] = e; mt[mcnt] = t; mcnt++; end
    check(req, {42'd0, cfg_rej_o}, {42'd0, exp_rej});
  endtask

  task automatic req(string r, logic [AW-1:0] a, logic [SW-1:0] sz, logic we);
    req_valid_i = 1'b1; req_addr_i = a; req_size_i = sz; req_we_i = we;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_we_i = 1'b0;
    check(r, {rsp_valid_o, rsp_we_o, rsp_hit_o, rsp_err_o, rsp_idx_o, rsp_tgt_o, rsp_offset_o},
          exp_rsp(a, sz, we));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R9 reset state
    check("R9 reset outputs",
          {rsp_valid_o, rsp_we_o, rsp_hit_o, rsp_err_o, rsp_idx_o, rsp_tgt_o, rsp_offset_o, cfg_rej_o},
          44'd0);
    req("R9 empty table miss", 32'h100, 4'd1, 1'b0);
    // R1 bounds
    cfg("R7 accept", 32'h100, 32'h10F, 4'd3);
    req("R1 inside end", 32'h10C, 4'd4, 1'b1);
    req("R1 straddle end", 32'h10D, 4'd4, 1'b0);
    req("R1 below start", 32'h0FF, 4'd1, 1'b0);
    req("R3 offset at start", 32'h100, 4'd1, 1'b0);
    // R6 illegal
    cfg("R6 reversed window", 32'h200, 32'h1FF, 4'd9);
    req("R6 not stored", 32'h200, 4'd1, 1'b0);
    // R2 overlap
    cfg("R7 accept", 32'h108, 32'h11F, 4'd5);
    req("R2 newest wins", 32'h10C, 4'd4, 1'b0);
    req("R2 older only", 32'h100, 4'd4, 1'b1);
    // R5 wrap and size zero
    cfg("R7 accept", 32'hFFFF_FFF0, 32'hFFFF_FFFF, 4'd7);
    req("R5 top fits", 32'hFFFF_FFFE, 4'd2, 1'b0);
    req("R5 wraps", 32'hFFFF_FFFE, 4'd3, 1'b0);
    req("R5 size zero", 32'h100, 4'd0, 1'b0);
    // R7 fill to full, then overflow
    for (int i = 0; i < 5; i++) cfg("R7 fill", 32'h400 + 32'(i*16), 32'h40F + 32'(i*16), 4'(i));
    cfg("R7 full reject", 32'h800, 32'h8FF, 4'd12);
    req("R7 overflow not stored", 32'h800, 4'd1, 1'b0);
    req("R3 last slot", 32'h443, 4'd2, 1'b1);
    // R8 idle
    @(negedge clk_i);
    check("R8 idle", {40'd0, rsp_valid_o, rsp_hit_o, rsp_err_o, rsp_we_o}, 44'd0);
    // Random rounds
    for (int r = 0; r < 40; r++) begin
      do_reset();
      for (int k = 0; k < 10; k++) begin
        logic [AW-1:0] s, e;
        s = 32'($urandom_range(0, 900));
        e = ($urandom_range(0, 9) == 0) ? s - 32'd1 : s + 32'($urandom_range(0, 200));
        cfg("R6 R7 random cfg", s, e, 4'($urandom));
      end
      for (int k = 0; k < 60; k++)
        req("R1 R2 R3 R4 random req", 32'($urandom_range(0, 1150)), 4'($urandom), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule